// File: doc/BRIEF.md
# UART Status Flag Controller

This block owns the status flags of a small serial port and keeps them coherent with the receiver core, the transmitter core and the CPU register interface. Each completed character is judged by the block: its parity is checked against the selected sense, it is moved into the receive holding register, and the block marks it ready, marks it as a parity error, or captures its multiprocessor address bit. On the transmit side the block tracks whether the transmit holding register is free and whether the line has gone idle after the final bit of a character.

Software clears a flag with a two-step handshake. It first reads the status register while the flag shows 1, then writes 0 to that flag. A write of 0 without that prior read does nothing, and writing 1 never sets a flag. A parity error freezes the receive channel until software clears it. In synchronous operation the same error also freezes the transmit channel.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset the status reads 0x09. Status bit positions: bit0 transmit-register-empty (TXE), bit1 receive-ready (RXR), bit2 parity error (PERR), bit3 transmit-done (TXD), bit4 received multiprocessor bit (MPB). Bits 7:5 read 0. rx_halt_o and tx_halt_o are low.
- R2: With parity enabled and asynchronous operation selected, a completed character sets PERR when the number of 1s in the data plus the parity bit is odd while pm_i=0, or even while pm_i=1.
- R3: Every accepted character is loaded into rdr_o. A character with a parity error leaves RXR unchanged. A character with good parity sets RXR.
- R4: While PERR is 1, rx_halt_o is high and completed characters are ignored: rdr_o, RXR and MPB do not change. tx_halt_o is high when PERR is 1 and sync_i is 1.
- R5: A flag among TXE, RXR and PERR clears only when a status write puts 0 in its bit and a status read that showed the flag as 1 has occurred since the last status write. A write of 0 without such a read leaves the flag set. Writing 1 has no effect.
- R6: When a setting event and a software clear reach the same flag in the same cycle, the flag ends up 1.
- R7: While re_i is 0, completed characters are ignored, and PERR and MPB keep their values.
- R8: TXD is set in the cycle after te_i is 0, or after tx_last_i arrives while TXE is 1. If TXE is 0 when tx_last_i arrives, TXD is not set.
- R9: A software clear of TXE, or a write to the transmit holding register, clears TXD. Status writes cannot change TXD directly.
- R10: With mp_fmt_i=1 in asynchronous operation, MPB takes the multiprocessor bit of each accepted character. Otherwise MPB is unaffected. Status writes cannot change MPB.
- R11: tx_take_i sets TXE. tdr_wr_i loads tdr_o with tdr_wdata_i.
- R12: When sync_i=1 or par_en_i=0, no parity check is made and every accepted character sets RXR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| te_i | input | 1 | Transmitter enable |
| re_i | input | 1 | Receiver enable |
| sync_i | input | 1 | 1 = synchronous operation |
| par_en_i | input | 1 | Parity enable (asynchronous operation) |
| pm_i | input | 1 | Parity sense: 0 even, 1 odd |
| mp_fmt_i | input | 1 | Multiprocessor format select |
| rx_done_i | input | 1 | Receiver strobe: character complete |
| rx_data_i | input | DW | Received data bits |
| rx_par_i | input | 1 | Received parity bit |
| rx_mpb_i | input | 1 | Received multiprocessor bit |
| tx_last_i | input | 1 | Transmitter strobe: final bit sent |
| tx_take_i | input | 1 | Transmitter has taken the holding register |
| sts_rd_i | input | 1 | Status register read strobe |
| sts_wr_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | 8 | Status write data |
| sts_rdata_o | output | 8 | Status read data |
| tdr_wr_i | input | 1 | Transmit holding register write strobe |
| tdr_wdata_i | input | DW | Transmit holding register write data |
| tdr_o | output | DW | Transmit holding register contents |
| rdr_o | output | DW | Receive holding register contents |
| rx_halt_o | output | 1 | Receive channel frozen by parity error |
| tx_halt_o | output | 1 | Transmit channel frozen (synchronous, parity error) |

## Verification
The assertions assume that every strobe is a single-cycle pulse. They also assume that mode inputs such as sync_i, pm_i and mp_fmt_i change only between characters, and that a status read that arms a clear comes before the write that uses it. The directed tasks raise each strobe for exactly one cycle. They drive all inputs at the falling edge and hold the mode bits steady across each character event. Every read-then-write pair is issued as two separate single-cycle strobes.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int unsigned STS_W   = 8;
  localparam int unsigned B_TXE   = 0;
  localparam int unsigned B_RXR   = 1;
  localparam int unsigned B_PERR  = 2;
  localparam int unsigned B_TXD   = 3;
  localparam int unsigned B_MPB   = 4;
  localparam logic [STS_W-1:0] STS_RST = 8'h09;

  typedef struct packed {
    logic mpb;
    logic txd;
    logic perr;
    logic rxr;
    logic txe;
  } flags_t;
endpackage

// File: rtl/uart_flag_clr.sv
// One software-clearable flag with read-as-1 arming.
module uart_flag_clr #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic sw_clr_o
);
  logic flag_q, arm_q;

  assign sw_clr_o = wr_i & arm_q & ~wbit_i;
  assign flag_o   = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      arm_q <= (rd_i & flag_q) | (arm_q & ~wr_i);
      if (set_i)         flag_q <= 1'b1;
      else if (sw_clr_o) flag_q <= 1'b0;
    end
  end

  // R5
  no_blind_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !arm_q && flag_q) |=> flag_q);
  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/uart_flag_parity.sv
module uart_flag_parity #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] data_i,
  input  logic          par_i,
  input  logic          odd_i,
  output logic          bad_o
);
  logic [DW:0] acc;
  assign acc[0] = par_i;
  for (genvar g = 0; g < DW; g++) begin : g_x
    assign acc[g+1] = acc[g] ^ data_i[g];
  end
  assign bad_o = acc[DW] ^ odd_i;
endmodule

// File: rtl/uart_flag_rx.sv
module uart_flag_rx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic          sync_i,
  input  logic          par_en_i,
  input  logic          pm_i,
  input  logic          mp_fmt_i,
  input  logic          rx_done_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_par_i,
  input  logic          rx_mpb_i,
  input  logic          sts_rd_i,
  input  logic          sts_wr_i,
  input  logic          w_rxr_i,
  input  logic          w_perr_i,
  output logic          rxr_o,
  output logic          perr_o,
  output logic          mpb_o,
  output logic [DW-1:0] rdr_o
);
  logic par_bad, accept, chk_par;
  logic [DW-1:0] rdr_q;
  logic mpb_q;
  logic rxr_clr_unused, perr_clr_unused;

  uart_flag_parity #(.DW(DW)) u_par (
    .data_i(rx_data_i), .par_i(rx_par_i), .odd_i(pm_i), .bad_o(par_bad)
  );

  assign chk_par = par_en_i & ~sync_i;
  assign accept  = rx_done_i & re_i & ~perr_o;

  uart_flag_clr #(.RST_VAL(1'b0)) u_rxr (
    .clk_i, .rst_ni, .set_i(accept & ~(chk_par & par_bad)),
    .rd_i(sts_rd_i), .wr_i(sts_wr_i), .wbit_i(w_rxr_i),
    .flag_o(rxr_o), .sw_clr_o(rxr_clr_unused)
  );

  uart_flag_clr #(.RST_VAL(1'b0)) u_perr (
    .clk_i, .rst_ni, .set_i(accept & chk_par & par_bad),
    .rd_i(sts_rd_i), .wr_i(sts_wr_i), .wbit_i(w_perr_i),
    .flag_o(perr_o), .sw_clr_o(perr_clr_unused)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr_q <= '0;
      mpb_q <= 1'b0;
    end else if (accept) begin
      rdr_q <= rx_data_i;
      if (mp_fmt_i && !sync_i) mpb_q <= rx_mpb_i;
    end
  end

  assign rdr_o = rdr_q;
  assign mpb_o = mpb_q;

  // R3
  perr_no_rxr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(perr_o) |-> !$rose(rxr_o));
  // R4
  halt_rdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |=> $stable(rdr_q));
  // R7
  re_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> ($stable(mpb_q) && !$rose(perr_o)));
endmodule

// File: rtl/uart_flag_tx.sv
module uart_flag_tx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          te_i,
  input  logic          tx_last_i,
  input  logic          tx_take_i,
  input  logic          tdr_wr_i,
  input  logic [DW-1:0] tdr_wdata_i,
  input  logic          sts_rd_i,
  input  logic          sts_wr_i,
  input  logic          w_txe_i,
  output logic          txe_o,
  output logic          txd_o,
  output logic [DW-1:0] tdr_o
);
  logic txe_clr, txd_q, txd_set;
  logic [DW-1:0] tdr_q;

  uart_flag_clr #(.RST_VAL(1'b1)) u_txe (
    .clk_i, .rst_ni, .set_i(tx_take_i),
    .rd_i(sts_rd_i), .wr_i(sts_wr_i), .wbit_i(w_txe_i),
    .flag_o(txe_o), .sw_clr_o(txe_clr)
  );

  assign txd_set = ~te_i | (tx_last_i & txe_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_q <= 1'b1;
      tdr_q <= '0;
    end else begin
      if (txd_set)                   txd_q <= 1'b1;
      else if (txe_clr || tdr_wr_i)  txd_q <= 1'b0;
      if (tdr_wr_i) tdr_q <= tdr_wdata_i;
    end
  end

  assign txd_o = txd_q;
  assign tdr_o = tdr_q;

  // R8
  te_off_txd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !te_i |=> txd_q);
  // R8
  last_txd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_last_i && txe_o) |=> txd_q);
  // R9
  txd_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txd_q) |-> $past(!te_i || tx_last_i));
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             te_i,
  input  logic             re_i,
  input  logic             sync_i,
  input  logic             par_en_i,
  input  logic             pm_i,
  input  logic             mp_fmt_i,
  input  logic             rx_done_i,
  input  logic [DW-1:0]    rx_data_i,
  input  logic             rx_par_i,
  input  logic             rx_mpb_i,
  input  logic             tx_last_i,
  input  logic             tx_take_i,
  input  logic             sts_rd_i,
  input  logic             sts_wr_i,
  input  logic [STS_W-1:0] sts_wdata_i,
  output logic [STS_W-1:0] sts_rdata_o,
  input  logic             tdr_wr_i,
  input  logic [DW-1:0]    tdr_wdata_i,
  output logic [DW-1:0]    tdr_o,
  output logic [DW-1:0]    rdr_o,
  output logic             rx_halt_o,
  output logic             tx_halt_o
);
  flags_t fl;

  uart_flag_rx #(.DW(DW)) u_rx (
    .clk_i, .rst_ni, .re_i, .sync_i, .par_en_i, .pm_i, .mp_fmt_i,
    .rx_done_i, .rx_data_i, .rx_par_i, .rx_mpb_i,
    .sts_rd_i, .sts_wr_i,
    .w_rxr_i(sts_wdata_i[B_RXR]), .w_perr_i(sts_wdata_i[B_PERR]),
    .rxr_o(fl.rxr), .perr_o(fl.perr), .mpb_o(fl.mpb), .rdr_o
  );

  uart_flag_tx #(.DW(DW)) u_tx (
    .clk_i, .rst_ni, .te_i, .tx_last_i, .tx_take_i, .tdr_wr_i, .tdr_wdata_i,
    .sts_rd_i, .sts_wr_i, .w_txe_i(sts_wdata_i[B_TXE]),
    .txe_o(fl.txe), .txd_o(fl.txd), .tdr_o
  );

  always_comb begin
    sts_rdata_o         = '0;
    sts_rdata_o[B_TXE]  = fl.txe;
    sts_rdata_o[B_RXR]  = fl.rxr;
    sts_rdata_o[B_PERR] = fl.perr;
    sts_rdata_o[B_TXD]  = fl.txd;
    sts_rdata_o[B_MPB]  = fl.mpb;
  end

  assign rx_halt_o = fl.perr;
  assign tx_halt_o = fl.perr & sync_i;

  // R4
  tx_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_halt_o |-> (rx_halt_o && sync_i));
endmodule

// File: tb/uart_flag_ctrl_test.sv
module uart_flag_ctrl_test;
  localparam int DW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic te, re, sync_m, par_en, pm, mp_fmt;
  logic rx_done, rx_par, rx_mpb, tx_last, tx_take;
  logic [DW-1:0] rx_data, tdr_wdata, tdr, rdr;
  logic sts_rd, sts_wr, tdr_wr, rx_halt, tx_halt;
  logic [7:0] sts_wdata, sts;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  uart_flag_ctrl #(.DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .te_i(te), .re_i(re), .sync_i(sync_m),
    .par_en_i(par_en), .pm_i(pm), .mp_fmt_i(mp_fmt),
    .rx_done_i(rx_done), .rx_data_i(rx_data), .rx_par_i(rx_par), .rx_mpb_i(rx_mpb),
    .tx_last_i(tx_last), .tx_take_i(tx_take),
    .sts_rd_i(sts_rd), .sts_wr_i(sts_wr), .sts_wdata_i(sts_wdata), .sts_rdata_o(sts),
    .tdr_wr_i(tdr_wr), .tdr_wdata_i(tdr_wdata), .tdr_o(tdr), .rdr_o(rdr),
    .rx_halt_o(rx_halt), .tx_halt_o(tx_halt)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rx_done = 0; tx_last = 0; tx_take = 0; sts_rd = 0; sts_wr = 0; tdr_wr = 0;
  endtask

  // one-cycle strobe helpers; result visible at following negedge
  task automatic step();
    @(negedge clk); idle();
  endtask

  task automatic rd();
    sts_rd = 1; step();
  endtask

  task automatic wr(input logic [7:0] d);
    sts_wr = 1; sts_wdata = d; step();
  endtask

  task automatic rx(input logic [7:0] d, input logic p, input logic m);
    rx_done = 1; rx_data = d; rx_par = p; rx_mpb = m; step();
  endtask

  task automatic clr(input int b);
    rd(); wr(~(8'h01 << b));
  endtask

  task automatic t_reset();
    chk("R1 status", sts, 8'h09);
    chk("R1 rx_halt", {7'd0, rx_halt}, 8'd0);
    chk("R1 tx_halt", {7'd0, tx_halt}, 8'd0);
  endtask

  task automatic t_tx();
    tdr_wr = 1; tdr_wdata = 8'hA5; step();
    chk("R9 tdr write clears TXD", sts, 8'h01);
    chk("R11 tdr load", tdr, 8'hA5);
    clr(0);
    chk("R5 TXE cleared", sts, 8'h00);
    tx_last = 1; step();
    chk("R8 no TXD when TXE=0", sts[3], 1'b0);
    tx_take = 1; step();
    chk("R11 TXE set", sts, 8'h01);
    tx_last = 1; step();
    chk("R8 TXD on last bit", sts, 8'h09);
    rd(); wr(8'hF7);
    chk("R9 TXD read-only", sts, 8'h09);
    tdr_wr = 1; tdr_wdata = 8'h3C; step();
    chk("R9 TXD clear", sts[3], 1'b0);
    te = 0; step();
    chk("R8 TE off sets TXD", sts[3], 1'b1);
    te = 1; step();
    rd(); wr(8'hFE);
    chk("R9 TXE clear clears TXD", sts[1:0] == 2'b00 && sts[3] == 1'b0, 1'b1);
    tx_take = 1; step();
  endtask

  task automatic t_rx();
    rx(8'h03, 1'b0, 1'b0);
    chk("R3 good char RXR", sts[1], 1'b1);
    chk("R3 rdr", rdr, 8'h03);
    wr(8'h00);
    chk("R5 blind write", sts[1], 1'b1);
    rd(); wr(8'hFF);
    chk("R5 write 1 ignored", sts[1], 1'b1);
    clr(1);
    chk("R5 RXR cleared", sts[1], 1'b0);
    pm = 1; rx(8'h01, 1'b0, 1'b0);
    chk("R2 odd sense ok", sts[2:1], 2'b01);
    clr(1);
    pm = 0; rx(8'h01, 1'b0, 1'b0);
    chk("R2 parity error", sts[2:1], 2'b10);
    chk("R3 rdr on error", rdr, 8'h01);
    chk("R4 rx_halt", {7'd0, rx_halt}, 8'd1);
    chk("R4 tx_halt async", {7'd0, tx_halt}, 8'd0);
    sync_m = 1; #1;
    chk("R4 tx_halt sync", {7'd0, tx_halt}, 8'd1);
    rx(8'h55, 1'b0, 1'b0);
    chk("R4 blocked rdr", rdr, 8'h01);
    chk("R4 blocked RXR", sts[1], 1'b0);
    sync_m = 0;
    re = 0; step();
    chk("R7 PERR kept", sts[2], 1'b1);
    re = 1;
    clr(2);
    chk("R5 PERR cleared", sts[2], 1'b0);
    chk("R4 halt released", {7'd0, rx_halt}, 8'd0);
    sync_m = 1; rx(8'h01, 1'b0, 1'b0);
    chk("R12 sync no check", sts[2:1], 2'b01);
    clr(1);
    sync_m = 0; par_en = 0; rx(8'h01, 1'b0, 1'b0);
    chk("R12 parity off", sts[2:1], 2'b01);
    par_en = 1;
  endtask

  task automatic t_set_wins();
    rd();
    sts_wr = 1; sts_wdata = 8'hFD; rx_done = 1; rx_data = 8'h0F; rx_par = 0; step();
    chk("R6 set wins", sts[1], 1'b1);
    chk("R6 rdr", rdr, 8'h0F);
    clr(1);
  endtask

  task automatic t_mpb();
    mp_fmt = 1; rx(8'h00, 1'b0, 1'b1);
    chk("R10 MPB captured", sts[4], 1'b1);
    re = 0; rx(8'h00, 1'b0, 1'b0);
    chk("R7 MPB kept RE off", sts[4], 1'b1);
    chk("R7 rx ignored", rdr, 8'h00);
    re = 1; mp_fmt = 0; rx(8'h00, 1'b0, 1'b0);
    chk("R10 MPB outside format", sts[4], 1'b1);
    rd(); wr(8'hEF);
    chk("R10 MPB read-only", sts[4], 1'b1);
    mp_fmt = 1; rx(8'h00, 1'b0, 1'b0);
    chk("R10 MPB recapture", sts[4], 1'b0);
  endtask

  initial begin
    idle(); te = 1; re = 1; sync_m = 0; par_en = 1; pm = 0; mp_fmt = 0;
    rx_data = 0; rx_par = 0; rx_mpb = 0; tdr_wdata = 0; sts_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx();
    t_rx();
    t_set_wins();
    t_mpb();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule